// File: doc/BRIEF.md
# AUX Request Sequencer

This block is a hardware master for an auxiliary-channel transceiver that sits behind a small register port. A client presents one request at a time: a 4-bit request code, a 20-bit address, a byte length and up to sixteen payload bytes. The sequencer builds the header and loads it with any payload into the transceiver's data registers. It then starts the transfer and retries according to the kind of failure. On success it unpacks the reply code and data, and it returns a status code, a byte count and the reply to the client.

Before any data is loaded, the sequencer checks three things. It rejects request codes it cannot carry and requests whose transmit or receive image would not fit the 20-byte register window. It also waits a bounded time for a channel that is still busy from earlier traffic. Waiting between attempts and between busy polls is counted in ticks of a one-microsecond strobe.

Top module: `aux_req_seq`

## Requirements
- R1: The transmit image is header byte 0 = {code[3:0], addr[19:16]}, byte 1 = addr[15:8], byte 2 = addr[7:0], byte 3 = length-1, then the payload (payload byte k taken from `req_wdata[8k+7:8k]`). Image bytes 4k..4k+3 are written to register address k+1, with the first byte in bits 31:24; bytes past the image size are zero.
- R2: The image size is 3 for a zero length, 4 for a non-empty read, and 4+length for a non-empty write. The start write to register 0 carries bits 31:28 all set, the image size in bits 24:20 and the key-select flag in bit 19.
- R3: A write expects 2 reply bytes. If 2 or more bytes arrive, the count is the second byte clamped to the length; otherwise the count is the length.
- R4: A read expects length+1 reply bytes. The received size is clamped to that, the reply code is bits 7:4 of the first byte, data byte j appears at `rsp_rdata[8j+7:8j]`, and the count is the clamped size minus one.
- R5: Register 0 bit 31 is the busy bit. It is read up to 3 times, with POLL_US ticks between reads. If all three reads show busy, status 1 (busy) is returned and no transfer is started.
- R6: A read of length 20 or more, or a write of length 17 or more, returns status 4 (too big) without any register access.
- R7: The request code is checked with bit 2 masked off. Only the masked values 0, 1, 2, 8 and 9 are accepted, and 1 and 9 are reads. Any other code returns status 5 (invalid) without any register access.
- R8: At most 5 attempts are made. Each attempt is followed by a write to register 0 with bits 30:28 set, which clears those status bits. A completion with timeout (bit 29) or without done (bit 30) starts the next attempt at once.
- R9: A completion with receive error (bit 28) is followed by a wait of RX_US ticks of `tick_us` before the next attempt.
- R10: The final status maps as follows: done clear → 1; receive error → 2 (I/O); timeout → 3; received size (bits 24:20) of 0 or above 20 → 1. Otherwise the status is 0 (ok).
- R11: A request with masked code 8 to address KEY_ADDR sets bit 19 of the start word; every other request leaves it clear.
- R12: `req_ready` is high only when the block is idle. `rsp_valid` holds with stable status and count until `rsp_ready` is high.
- R13: After reset, `req_ready` is 1, `rsp_valid` is 0 and no register access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_cmd | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Length in bytes |
| req_wdata | input | 128 | Write payload, byte k at bits 8k+7:8k |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_status | output | 3 | 0 ok, 1 busy, 2 I/O, 3 timeout, 4 too big, 5 invalid |
| rsp_reply | output | 4 | Reply code |
| rsp_count | output | 5 | Byte count |
| rsp_rdata | output | 152 | Read data, byte j at bits 8j+7:8j |
| tick_us | input | 1 | One-microsecond strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 3 | 0 control, 1..5 data |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid in the strobe cycle |

## Verification
The bench runs requests against a scripted transceiver model that plays back one outcome per attempt. The patterns cover clean native and I2C reads and writes, short-write replies, zero-length requests and over-long replies. Together they separate the three header sizes and the two reply decodings. Outcome sequences of timeouts, receive errors and missing completions followed by success tell immediate retries from delayed ones, by the spacing of the start writes, and show where the attempt limit falls. Busy channels, oversize and invalid codes, out-of-range received sizes and the key-select address check the early exits and the control-word flag.

// File: rtl/aux_req_seq.sv
module aux_req_seq #(
  parameter int MAXB = 20,
  parameter int LENW = 5,
  parameter int POLL_US = 1000,
  parameter int RX_US = 400,
  parameter int TRIES = 5,
  parameter int POLLS = 3,
  parameter logic [19:0] KEY_ADDR = 20'h68007
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [3:0]              req_cmd,
  input  logic [19:0]             req_addr,
  input  logic [LENW-1:0]         req_len,
  input  logic [8*(MAXB-4)-1:0]   req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [2:0]              rsp_status,
  output logic [3:0]              rsp_reply,
  output logic [LENW-1:0]         rsp_count,
  output logic [8*(MAXB-1)-1:0]   rsp_rdata,
  input  logic                    tick_us,
  output logic                    reg_wr,
  output logic                    reg_rd,
  output logic [2:0]              reg_addr,
  output logic [31:0]             reg_wdata,
  input  logic [31:0]             reg_rdata
);
  localparam int NW = MAXB / 4;
  localparam int PAYB = MAXB - 4;
  localparam int IW = $clog2(NW + 1);
  localparam int TW = $clog2((POLL_US > RX_US ? POLL_US : RX_US) + 1);
  localparam int AW = $clog2(TRIES + 1);
  localparam int PW = $clog2(POLLS + 1);
  localparam logic [2:0] ST_OK = 3'd0, ST_BUSY = 3'd1, ST_IO = 3'd2,
                         ST_TMO = 3'd3, ST_BIG = 3'd4, ST_INV = 3'd5;

  typedef enum logic [3:0] {IDLE, CHK, POLL, PWAIT, LOAD, START, WAITB,
                            CLEAR, RWAIT, FIN, UNLOAD, RESP} st_t;
  st_t st;

  logic [3:0]        cmd;
  logic [19:0]       addr;
  logic [LENW-1:0]   len;
  logic [8*PAYB-1:0] pay;
  logic [TW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [AW-1:0]     tries;
  logic [PW-1:0]     polls;
  logic [31:0]       stat;
  logic [8*MAXB-1:0] rxb;
  logic [2:0]        status;

  wire [3:0] mcmd   = cmd & 4'b1011;
  wire       is_rd  = (mcmd == 4'd1) || (mcmd == 4'd9);
  wire       ok_cmd = (mcmd == 4'd0) || (mcmd == 4'd1) || (mcmd == 4'd2) ||
                      (mcmd == 4'd8) || (mcmd == 4'd9);
  wire [5:0] len6   = {1'b0, len};
  wire [5:0] txn    = (len == '0) ? 6'd3 : (is_rd ? 6'd4 : len6 + 6'd4);
  wire [5:0] rxexp  = is_rd ? len6 + 6'd1 : 6'd2;
  wire       too_big = (txn > 6'(MAXB)) || (rxexp > 6'(MAXB));
  wire [5:0] nwtx   = (txn + 6'd3) >> 2;
  wire [5:0] rsize  = {1'b0, stat[24:20]};
  wire [5:0] rxn    = (rsize > rxexp) ? rxexp : rsize;
  wire [5:0] nwrx   = (rxn + 6'd3) >> 2;
  wire       key    = (mcmd == 4'd8) && (addr == KEY_ADDR);
  wire       last   = (tries == AW'(TRIES - 1));

  logic [8*PAYB-1:0] pay_r;
  logic [8*MAXB-1:0] txs, txm;
  logic [31:0]       txword;
  for (genvar g = 0; g < PAYB; g++) begin : g_pay
    assign pay_r[8*(PAYB-1-g) +: 8] = pay[8*g +: 8];
  end
  assign txs = {cmd, addr, 8'(len6 - 6'd1), pay_r};
  for (genvar g = 0; g < MAXB; g++) begin : g_msk
    assign txm[8*(MAXB-1-g) +: 8] = (6'(g) < txn) ? txs[8*(MAXB-1-g) +: 8] : 8'h00;
  end
  always_comb begin
    txword = '0;
    for (int k = 0; k < NW; k++)
      if (idx == IW'(k)) txword = txm[32*(NW-1-k) +: 32];
  end

  assign req_ready = (st == IDLE);
  assign rsp_valid = (st == RESP);
  assign reg_rd    = (st == POLL) || (st == WAITB) || (st == UNLOAD);
  assign reg_wr    = (st == LOAD) || (st == START) || (st == CLEAR);
  assign reg_addr  = (st == LOAD || st == UNLOAD) ? 3'(idx) + 3'd1 : 3'd0;
  assign reg_wdata = (st == LOAD)  ? txword :
                     (st == START) ? {4'hF, 3'b000, txn[4:0], key, 19'd0} :
                     (st == CLEAR) ? {1'b0, 3'b111, stat[27:0]} : 32'd0;

  wire [7:0] b1 = rxb[15:8];
  wire [LENW-1:0] wr_cnt = (rxn > 6'd1) ? ((b1 > 8'(len)) ? len : LENW'(b1)) : len;
  wire [LENW-1:0] rd_cnt = LENW'(rxn - 6'd1);
  assign rsp_status = status;
  assign rsp_count  = (status != ST_OK) ? '0 : (is_rd ? rd_cnt : wr_cnt);
  assign rsp_reply  = rxb[7:4];
  assign rsp_rdata  = rxb[8*MAXB-1:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cmd <= '0; addr <= '0; len <= '0; pay <= '0; cnt <= '0;
      idx <= '0; tries <= '0; polls <= '0; stat <= '0; rxb <= '0; status <= ST_OK;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          cmd <= req_cmd; addr <= req_addr; len <= req_len; pay <= req_wdata;
          rxb <= '0; st <= CHK;
        end
        CHK: begin
          polls <= '0;
          if (!ok_cmd) begin status <= ST_INV; st <= RESP; end
          else if (too_big) begin status <= ST_BIG; st <= RESP; end
          else st <= POLL;
        end
        POLL: begin
          cnt <= '0; idx <= '0; tries <= '0;
          if (!reg_rdata[31]) st <= LOAD;
          else if (polls == PW'(POLLS - 1)) begin status <= ST_BUSY; st <= RESP; end
          else begin polls <= polls + 1'b1; st <= PWAIT; end
        end
        PWAIT: if (tick_us) begin
          if (cnt == TW'(POLL_US - 1)) st <= POLL; else cnt <= cnt + 1'b1;
        end
        LOAD: if (6'(idx) == nwtx - 6'd1) st <= START; else idx <= idx + 1'b1;
        START: st <= WAITB;
        WAITB: if (!reg_rdata[31]) begin stat <= reg_rdata; st <= CLEAR; end
        CLEAR: begin
          tries <= tries + 1'b1; idx <= '0; cnt <= '0;
          if (stat[28]) st <= last ? FIN : RWAIT;
          else if (stat[29] || !stat[30]) st <= last ? FIN : LOAD;
          else st <= FIN;
        end
        RWAIT: if (tick_us) begin
          if (cnt == TW'(RX_US - 1)) st <= LOAD; else cnt <= cnt + 1'b1;
        end
        FIN: begin
          idx <= '0; st <= RESP;
          if (!stat[30]) status <= ST_BUSY;
          else if (stat[28]) status <= ST_IO;
          else if (stat[29]) status <= ST_TMO;
          else if (rsize == 6'd0 || rsize > 6'(MAXB)) status <= ST_BUSY;
          else begin status <= ST_OK; st <= UNLOAD; end
        end
        UNLOAD: begin
          for (int k = 0; k < NW; k++)
            if (idx == IW'(k))
              for (int m = 0; m < 4; m++) rxb[8*(4*k+m) +: 8] <= reg_rdata[8*(3-m) +: 8];
          if (6'(idx) == nwrx - 6'd1) st <= RESP; else idx <= idx + 1'b1;
        end
        RESP: if (rsp_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  logic       touched;
  logic [3:0] nstart;
  logic [3:0] nctlrd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touched <= 1'b0; nstart <= '0; nctlrd <= '0;
    end else if (st == IDLE && req_valid) begin
      touched <= 1'b0; nstart <= '0; nctlrd <= '0;
    end else begin
      if (reg_wr || reg_rd) touched <= 1'b1;
      if (reg_wr && reg_addr == 3'd0 && reg_wdata[31]) nstart <= nstart + 1'b1;
      if (reg_rd && reg_addr == 3'd0 && nctlrd != 4'hF) nctlrd <= nctlrd + 1'b1;
    end
  end

  // R6 R7
  no_touch_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_status == ST_BIG || rsp_status == ST_INV) |-> !touched);
  // R8
  attempt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nstart <= 4'(TRIES));
  // R5
  busy_poll_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == ST_BUSY && nstart == 4'd0 |-> nctlrd == 4'(POLLS));
  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_count));
  // R3
  write_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == ST_OK && !is_rd |-> rsp_count <= len);
  // R12
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !reg_wr && !reg_rd);
endmodule

// File: tb/aux_req_seq_tb_top.sv
module aux_req_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         req_valid = 1'b0, req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_wdata = '0;
  logic         rsp_valid, rsp_ready = 1'b1;
  logic [2:0]   rsp_status;
  logic [3:0]   rsp_reply;
  logic [4:0]   rsp_count;
  logic [151:0] rsp_rdata;
  logic         tick_us = 1'b1;
  logic         reg_wr, reg_rd;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;

  aux_req_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_reply(rsp_reply), .rsp_count(rsp_count), .rsp_rdata(rsp_rdata),
    .tick_us(tick_us), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  int total = 0, bad = 0;
  task automatic chk(bit ok, string tag, logic [159:0] act, logic [159:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // transceiver model
  logic [31:0] m_ctl = '0;
  logic [31:0] m_data [5];
  logic [31:0] txlog [5];
  logic [31:0] last_ctl = '0;
  int busy_hold = 0, lat = 0, cyc = 0, nstarts = 0, nacc = 0, nctlrd = 0, tick_div = 1;
  int start_cyc [$];
  int oq_kind [$];
  int oq_size [$];
  logic [159:0] oq_words [$];

  assign reg_rdata = (reg_addr == 3'd0) ? (m_ctl | ((busy_hold > 0) ? 32'h8000_0000 : 32'h0)) :
                     (reg_addr <= 3'd5) ? m_data[reg_addr - 3'd1] : 32'h0;

  initial for (int i = 0; i < 5; i++) begin m_data[i] = '0; txlog[i] = '0; end

  always @(posedge clk) begin
    cyc++;
    if (reg_wr || reg_rd) nacc++;
    if (reg_rd && reg_addr == 3'd0) begin
      nctlrd++;
      if (busy_hold > 0) busy_hold <= busy_hold - 1;
    end
    if (reg_wr && reg_addr == 3'd0) begin
      if (reg_wdata[31]) begin
        m_ctl[31] <= 1'b1; m_ctl[30:28] <= 3'b000;
        last_ctl <= reg_wdata; nstarts++; start_cyc.push_back(cyc); lat <= 4;
      end else m_ctl[30:28] <= m_ctl[30:28] & ~reg_wdata[30:28];
    end else if (reg_wr && reg_addr >= 3'd1 && reg_addr <= 3'd5) txlog[reg_addr - 3'd1] <= reg_wdata;
    if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        int k; int sz; logic [159:0] w;
        k = 0; sz = 1; w = '0;
        if (oq_kind.size() > 0) begin k = oq_kind.pop_front(); sz = oq_size.pop_front(); w = oq_words.pop_front(); end
        m_ctl[31] <= 1'b0;
        m_ctl[30] <= (k != 3);
        m_ctl[29] <= (k == 1);
        m_ctl[28] <= (k == 2);
        m_ctl[24:20] <= 5'(sz);
        for (int i = 0; i < 5; i++) m_data[i] <= w[32*(4-i) +: 32];
      end
    end
  end

  always @(negedge clk) tick_us <= ((cyc % tick_div) == 0);

  task automatic outc(int kind, int size, logic [159:0] words);
    oq_kind.push_back(kind); oq_size.push_back(size); oq_words.push_back(words);
  endtask

  // scoreboard
  int           eq_st [$];
  int           eq_cnt [$];
  int           eq_rep [$];
  int           eq_msk [$];
  logic [151:0] eq_dat [$];
  string        eq_tag [$];

  always @(negedge clk) begin
    if (rsp_valid && rsp_ready) begin
      if (eq_st.size() == 0) chk(1'b0, "unexpected response", 160'(rsp_status), 160'hFF);
      else begin
        int st; int cn; int rp; int mk; logic [151:0] d; string t; logic [151:0] mask;
        st = eq_st.pop_front(); cn = eq_cnt.pop_front(); rp = eq_rep.pop_front();
        mk = eq_msk.pop_front(); d = eq_dat.pop_front(); t = eq_tag.pop_front();
        mask = '0;
        for (int i = 0; i < mk; i++) mask[8*i +: 8] = 8'hFF;
        chk(rsp_status == 3'(st), {t, " status"}, 160'(rsp_status), 160'(st));
        chk(rsp_count == 5'(cn), {t, " count"}, 160'(rsp_count), 160'(cn));
        if (rp >= 0) chk(rsp_reply == 4'(rp), {t, " reply"}, 160'(rsp_reply), 160'(rp));
        if (mk > 0) chk((rsp_rdata & mask) == (d & mask), {t, " data"}, 160'(rsp_rdata & mask), 160'(d & mask));
      end
    end
  end

  task automatic issue(logic [3:0] c, logic [19:0] a, logic [4:0] l, logic [127:0] w,
                       int est, int ecnt, int erep, int emsk, logic [151:0] edat, string tag);
    eq_st.push_back(est); eq_cnt.push_back(ecnt); eq_rep.push_back(erep);
    eq_msk.push_back(emsk); eq_dat.push_back(edat); eq_tag.push_back(tag);
    @(negedge clk);
    nstarts = 0; nacc = 0; nctlrd = 0; start_cyc.delete();
    req_cmd = c; req_addr = a; req_len = l; req_wdata = w; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (eq_st.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic req(logic [3:0] c, logic [19:0] a, logic [4:0] l, logic [127:0] w,
                     int est, int ecnt, int erep, int emsk, logic [151:0] edat, string tag);
    issue(c, a, l, w, est, ecnt, erep, emsk, edat, tag);
    wait_done();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(req_ready == 1'b1, "R13 ready", 160'(req_ready), 160'd1);
    chk(rsp_valid == 1'b0, "R13 rsp_valid", 160'(rsp_valid), 160'd0);
    chk(!reg_wr && !reg_rd, "R13 no access", 160'({reg_wr, reg_rd}), 160'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R4 native read, len 4
    outc(0, 5, {32'h0011_2233, 32'h4400_0000, 96'd0});
    req(4'h9, 20'h12345, 5'd4, '0, 0, 4, 0, 4, 152'h44332211, "R4 read");
    chk(txlog[0] == 32'h9123_4503, "R1 read header", 160'(txlog[0]), 160'h91234503);
    chk(last_ctl[24:20] == 5'd4, "R2 read size", 160'(last_ctl[24:20]), 160'd4);
    chk(last_ctl[31:28] == 4'hF && last_ctl[19] == 1'b0, "R2 start bits", 160'(last_ctl), 160'hF0400000);
    chk(nstarts == 1, "R8 single attempt", 160'(nstarts), 160'd1);

    // R1 R2 R3 native write, 1-byte reply
    outc(0, 1, {32'h0000_0000, 128'd0});
    req(4'h8, 20'h00100, 5'd2, 128'hBBAA, 0, 2, 0, 0, '0, "R3 write full");
    chk(txlog[0] == 32'h8001_0001, "R1 write header", 160'(txlog[0]), 160'h80010001);
    chk(txlog[1] == 32'hAABB_0000, "R1 write payload", 160'(txlog[1]), 160'hAABB0000);
    chk(last_ctl[24:20] == 5'd6, "R2 write size", 160'(last_ctl[24:20]), 160'd6);

    // R3 short write replies
    outc(0, 2, {32'h1007_0000, 128'd0});
    req(4'h0, 20'h00050, 5'd3, 128'h030201, 0, 3, 1, 0, '0, "R3 clamp");
    outc(0, 2, {32'h1001_0000, 128'd0});
    req(4'h0, 20'h00050, 5'd3, 128'h030201, 0, 1, 1, 0, '0, "R3 short");

    // R2 R4 zero-length I2C read with continuation bit
    outc(0, 1, {32'h2000_0000, 128'd0});
    req(4'h5, 20'h00050, 5'd0, '0, 0, 0, 2, 0, '0, "R4 zero read");
    chk(txlog[0] == 32'h5000_5000, "R1 zero header", 160'(txlog[0]), 160'h50005000);
    chk(last_ctl[24:20] == 5'd3, "R2 zero size", 160'(last_ctl[24:20]), 160'd3);

    // R4 over-long reply clamped
    outc(0, 8, {32'h00A1_A2A3, 32'hA4A5_A6A7, 96'd0});
    req(4'h1, 20'h00050, 5'd2, '0, 0, 2, 0, 2, 152'hA2A1, "R4 clamp");

    // R8 timeouts retry at once
    outc(1, 0, '0); outc(1, 0, '0); outc(0, 2, {32'h0055_0000, 128'd0});
    req(4'h9, 20'h00200, 5'd1, '0, 0, 1, 0, 1, 152'h55, "R8 retry");
    chk(nstarts == 3, "R8 starts", 160'(nstarts), 160'd3);
    if (start_cyc.size() == 3)
      chk(start_cyc[1] - start_cyc[0] < 40, "R8 immediate", 160'(start_cyc[1] - start_cyc[0]), 160'd40);

    // R9 receive error waits
    outc(2, 0, '0); outc(0, 2, {32'h0066_0000, 128'd0});
    req(4'h9, 20'h00200, 5'd1, '0, 0, 1, 0, 1, 152'h66, "R9 wait");
    if (start_cyc.size() == 2)
      chk(start_cyc[1] - start_cyc[0] >= 400 && start_cyc[1] - start_cyc[0] < 460,
          "R9 gap", 160'(start_cyc[1] - start_cyc[0]), 160'd400);
    else chk(1'b0, "R9 starts", 160'(start_cyc.size()), 160'd2);

    // R9 wait counts ticks, not cycles
    tick_div = 2;
    outc(2, 0, '0); outc(0, 2, {32'h0067_0000, 128'd0});
    req(4'h9, 20'h00200, 5'd1, '0, 0, 1, 0, 1, 152'h67, "R9 tick");
    if (start_cyc.size() == 2)
      chk(start_cyc[1] - start_cyc[0] >= 800, "R9 tick gap", 160'(start_cyc[1] - start_cyc[0]), 160'd800);
    else chk(1'b0, "R9 tick starts", 160'(start_cyc.size()), 160'd2);
    tick_div = 1;

    // R8 R10 exhausted attempts
    for (int i = 0; i < 5; i++) outc(1, 0, '0);
    req(4'h9, 20'h00300, 5'd1, '0, 3, 0, -1, 0, '0, "R10 timeout");
    chk(nstarts == 5, "R8 limit timeout", 160'(nstarts), 160'd5);
    for (int i = 0; i < 5; i++) outc(2, 0, '0);
    req(4'h9, 20'h00300, 5'd1, '0, 2, 0, -1, 0, '0, "R10 io");
    chk(nstarts == 5, "R8 limit rxerr", 160'(nstarts), 160'd5);
    for (int i = 0; i < 5; i++) outc(3, 0, '0);
    req(4'h9, 20'h00300, 5'd1, '0, 1, 0, -1, 0, '0, "R10 not done");

    // R10 forbidden received sizes
    outc(0, 0, '0);
    req(4'h9, 20'h00300, 5'd1, '0, 1, 0, -1, 0, '0, "R10 size0");
    outc(0, 21, '0);
    req(4'h9, 20'h00300, 5'd1, '0, 1, 0, -1, 0, '0, "R10 size21");
    chk(nstarts == 1, "R10 no retry", 160'(nstarts), 160'd1);

    // R5 busy channel
    busy_hold = 3;
    req(4'h9, 20'h00400, 5'd1, '0, 1, 0, -1, 0, '0, "R5 busy");
    chk(nstarts == 0 && nctlrd == 3, "R5 polls", 160'({nstarts[7:0], nctlrd[7:0]}), 160'h0003);
    busy_hold = 2;
    outc(0, 2, {32'h0077_0000, 128'd0});
    req(4'h9, 20'h00400, 5'd1, '0, 0, 1, 0, 1, 152'h77, "R5 freed");

    // R6 size limits
    req(4'h9, 20'h00500, 5'd20, '0, 4, 0, -1, 0, '0, "R6 read20");
    chk(nacc == 0, "R6 no access read", 160'(nacc), 160'd0);
    req(4'h8, 20'h00500, 5'd17, '0, 4, 0, -1, 0, '0, "R6 write17");
    chk(nacc == 0, "R6 no access write", 160'(nacc), 160'd0);
    outc(0, 1, '0);
    req(4'h8, 20'h00500, 5'd16, 128'hF0EE_DDCC_BBAA_9988_7766_5544_3322_1100, 0, 16, 0, 0, '0, "R6 write16");
    chk(txlog[4] == 32'hCCDD_EEF0, "R1 last word", 160'(txlog[4]), 160'hCCDDEEF0);
    chk(last_ctl[24:20] == 5'd20, "R2 size20", 160'(last_ctl[24:20]), 160'd20);

    // R7 invalid codes
    req(4'h3, 20'h00600, 5'd1, '0, 5, 0, -1, 0, '0, "R7 code3");
    req(4'hB, 20'h00600, 5'd1, '0, 5, 0, -1, 0, '0, "R7 codeB");
    chk(nacc == 0, "R7 no access", 160'(nacc), 160'd0);

    // R11 key select
    outc(0, 1, '0);
    req(4'h8, 20'h68007, 5'd1, 128'h1, 0, 1, 0, 0, '0, "R11 key");
    chk(last_ctl[19] == 1'b1, "R11 key set", 160'(last_ctl[19]), 160'd1);
    outc(0, 1, '0);
    req(4'hC, 20'h68007, 5'd1, 128'h1, 0, 1, 0, 0, '0, "R11 key mot");
    chk(last_ctl[19] == 1'b1, "R11 key mot set", 160'(last_ctl[19]), 160'd1);
    outc(0, 1, '0);
    req(4'h8, 20'h68008, 5'd1, 128'h1, 0, 1, 0, 0, '0, "R11 other addr");
    chk(last_ctl[19] == 1'b0, "R11 key clear", 160'(last_ctl[19]), 160'd0);
    outc(0, 1, '0);
    req(4'h0, 20'h68007, 5'd1, 128'h1, 0, 1, 0, 0, '0, "R11 i2c");
    chk(last_ctl[19] == 1'b0, "R11 i2c clear", 160'(last_ctl[19]), 160'd0);

    // R12 response hold
    rsp_ready = 1'b0;
    outc(0, 2, {32'h0088_0000, 128'd0});
    issue(4'h9, 20'h00700, 5'd1, '0, 0, 1, 0, 1, 152'h88, "R12 hold");
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready, "R12 held", 160'({rsp_valid, req_ready}), 160'b10);
    end
    rsp_ready = 1'b1;
    wait_done();
    chk(req_ready == 1'b1, "R12 back idle", 160'(req_ready), 160'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule